// File: doc/BRIEF.md
# Forward Frame Address Classifier

This block sits right after the bit-level receiver of a two-wire lighting control bus. Each received forward frame arrives as a one-cycle strobe with two bytes, an address byte and a data byte. The block decides whether the frame concerns this device. It compares the address byte against the device's stored short address and its 16-bit group membership mask. Broadcast and special-command ranges match every device.

When a frame matches, the block labels it with exactly one of three types and passes the data byte on with that label. A direct level means the data byte is a light level. A standard command means the data byte is a command opcode. A special command means the address byte itself is the opcode. Command execution downstream reads only these flags and the forwarded byte. It never decodes the address byte again.

The address space is split by the upper bits of the address byte. A clear bit 7 selects the short-address range. The pattern 100 in bits 7..5 selects the group range. Values 0xA0 through 0xFD are special commands. 0xFE and 0xFF are broadcast. In the short, group and broadcast ranges, bit 0 of the address byte is the selector.

Top module: `fwd_addr_classifier`

## Requirements
- R1: An address byte with bit 7 clear matches when bits 6..1 equal the stored short address and that stored value is in the range 0 to 63.
- R2: A stored short address of 64 or above (0xFF is the marker for "none assigned") makes every short-range frame a non-match, whatever bits 6..1 hold.
- R3: An address byte 100GGGGx (0x80 to 0x9F) matches only when bit GGGG (bits 4..1) of the group membership mask is 1.
- R4: Address bytes 0xFE and 0xFF are broadcast and match regardless of short address and group mask.
- R5: Address bytes 0xA0 to 0xFD match every device and raise only the special flag, whatever their bit 0.
- R6: For a matching short, group or broadcast frame, address bit 0 equal to 0 raises only the direct-level flag, and 1 raises only the command flag.
- R7: Every input strobe produces an output strobe exactly one clock later, and that strobe carries that frame's data byte. Back-to-back strobes give back-to-back results.
- R8: A frame that does not match still produces an output strobe, with the match flag and all three type flags at 0.
- R9: After reset the output strobe, the match flag, all type flags and the data output are 0.
- R10: At most one type flag is ever high, and none is high unless the output strobe and the match flag are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe: a decoded forward frame is present |
| in_addr | input | 8 | Address byte of the frame |
| in_data | input | 8 | Data byte of the frame |
| my_short | input | 8 | Stored short address; 64 or above means none |
| group_mask | input | 16 | Group membership, bit n set means member of group n |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_for_me | output | 1 | Frame addresses this device |
| out_direct | output | 1 | Data byte is a direct level |
| out_command | output | 1 | Data byte is a standard command |
| out_special | output | 1 | Address byte is a special command code |
| out_data | output | 8 | Data byte of the frame last strobed in |

## Verification
The bench's checks and the embedded assertions catch a wrong internal state at the ports on the output strobe of the frame it affects, one clock after the input strobe. A bad range boundary shows up as a type flag on the wrong side of 0x80, 0xA0 or 0xFE. A wrong group index shows up as a match on an unset mask bit, and a lost selector shows up as a direct level reported for a command. Because nothing is held from frame to frame except the data byte, no error can stay hidden past the strobe of the frame that exposes it. The stimulus therefore targets the range edges, the unassigned marker against an address whose low six bits equal 63, and two frames on consecutive cycles.

// File: rtl/fac_pkg.sv
`timescale 1ns/1ps
package fac_pkg;

    localparam int BYTE_W     = 8;
    localparam int SHORT_W    = 6;
    localparam int GROUP_W    = 4;
    localparam int NUM_GROUPS = 1 << GROUP_W;

    localparam logic [BYTE_W-1:0] SPECIAL_LO = 8'hA0;
    localparam logic [BYTE_W-1:0] SPECIAL_HI = 8'hFD;

    typedef enum logic [2:0] {
        AK_NONE    = 3'd0,
        AK_SHORT   = 3'd1,
        AK_GROUP   = 3'd2,
        AK_BCAST   = 3'd3,
        AK_SPECIAL = 3'd4
    } addr_kind_e;

    typedef struct packed {
        addr_kind_e         kind;
        logic [SHORT_W-1:0] index;
        logic               sel;
    } addr_info_t;

    typedef struct packed {
        logic              valid;
        logic              for_me;
        logic              direct;
        logic              command;
        logic              special;
        logic [BYTE_W-1:0] data;
    } fwd_result_t;

    function automatic addr_kind_e classify(input logic [BYTE_W-1:0] a);
        addr_kind_e k;
        if (!a[BYTE_W-1])
            k = AK_SHORT;
        else if (a[BYTE_W-1 -: 3] == 3'b100)
            k = AK_GROUP;
        else if (a[BYTE_W-1:1] == {(BYTE_W-1){1'b1}})
            k = AK_BCAST;
        else if (a >= SPECIAL_LO && a <= SPECIAL_HI)
            k = AK_SPECIAL;
        else
            k = AK_NONE;
        return k;
    endfunction

    function automatic logic short_assigned(input logic [BYTE_W-1:0] s);
        return (s[BYTE_W-1:SHORT_W] == '0);
    endfunction

endpackage

// File: rtl/fac_addr_decode.sv
`timescale 1ns/1ps
module fac_addr_decode
    import fac_pkg::*;
(
    input  logic [BYTE_W-1:0] addr,
    output addr_info_t        info
);

    always_comb begin
        info.kind = classify(addr);
        info.sel  = addr[0];
        if (info.kind == AK_GROUP)
            info.index = {{(SHORT_W-GROUP_W){1'b0}}, addr[GROUP_W:1]};
        else
            info.index = addr[SHORT_W:1];
    end

endmodule

// File: rtl/fac_match.sv
`timescale 1ns/1ps
module fac_match
    import fac_pkg::*;
#(
    parameter int N_GROUPS = NUM_GROUPS
) (
    input  addr_info_t          info,
    input  logic [BYTE_W-1:0]   my_short,
    input  logic [N_GROUPS-1:0] group_mask,
    output logic                hit
);

    logic [N_GROUPS-1:0] grp_hit;
    logic                short_hit;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        assign grp_hit[g] = group_mask[g] && (info.index == SHORT_W'(g));
    end

    assign short_hit = short_assigned(my_short) &&
                       (info.index == my_short[SHORT_W-1:0]);

    always_comb begin
        unique case (info.kind)
            AK_SHORT:   hit = short_hit;
            AK_GROUP:   hit = |grp_hit;
            AK_BCAST:   hit = 1'b1;
            AK_SPECIAL: hit = 1'b1;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fac_out_reg.sv
`timescale 1ns/1ps
module fac_out_reg
    import fac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  addr_info_t        info,
    input  logic              hit,
    input  logic [BYTE_W-1:0] data,
    output fwd_result_t       res
);

    logic is_special;
    assign is_special = (info.kind == AK_SPECIAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid   <= in_valid;
            res.for_me  <= in_valid && hit;
            res.special <= in_valid && hit && is_special;
            res.direct  <= in_valid && hit && !is_special && !info.sel;
            res.command <= in_valid && hit && !is_special && info.sel;
            if (in_valid)
                res.data <= data;
        end
    end

    // R10
    one_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.for_me) |-> ($countones({res.direct, res.command, res.special}) == 1));

    // R10
    quiet_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(res.valid && res.for_me) |-> ({res.direct, res.command, res.special} == 3'b000));

    // R6
    selector_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && hit && !is_special && info.sel) |=> res.command);

endmodule

// File: rtl/fwd_addr_classifier.sv
`timescale 1ns/1ps
module fwd_addr_classifier
    import fac_pkg::*;
#(
    parameter int N_GROUPS = NUM_GROUPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_addr,
    input  logic [7:0]          in_data,
    input  logic [7:0]          my_short,
    input  logic [N_GROUPS-1:0] group_mask,
    output logic                out_valid,
    output logic                out_for_me,
    output logic                out_direct,
    output logic                out_command,
    output logic                out_special,
    output logic [7:0]          out_data
);

    addr_info_t  info;
    logic        hit;
    fwd_result_t res;

    fac_addr_decode u_dec (
        .addr (in_addr),
        .info (info)
    );

    fac_match #(.N_GROUPS(N_GROUPS)) u_match (
        .info       (info),
        .my_short   (my_short),
        .group_mask (group_mask),
        .hit        (hit)
    );

    fac_out_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .info     (info),
        .hit      (hit),
        .data     (in_data),
        .res      (res)
    );

    assign out_valid   = res.valid;
    assign out_for_me  = res.for_me;
    assign out_direct  = res.direct;
    assign out_command = res.command;
    assign out_special = res.special;
    assign out_data    = res.data;

    // R7
    strobe_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_data == $past(in_data)));

    // R5
    special_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_addr >= 8'hA0 && in_addr <= 8'hFD) |=> (out_for_me && out_special));

    // R4
    bcast_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_addr[7:1] == 7'h7F) |=> (out_for_me && !out_special));

    // R2
    unassigned_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_addr[7] && my_short[7:6] != 2'b00) |=> !out_for_me);

endmodule

// File: tb/fwd_addr_classifier_test.sv
`timescale 1ns/1ps
module fwd_addr_classifier_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_addr, in_data, my_short;
    logic [15:0] group_mask;
    logic        out_valid, out_for_me, out_direct, out_command, out_special;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fwd_addr_classifier uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .my_short(my_short), .group_mask(group_mask),
        .out_valid(out_valid), .out_for_me(out_for_me), .out_direct(out_direct),
        .out_command(out_command), .out_special(out_special), .out_data(out_data)
    );

    // flags packed as {valid, for_me, direct, command, special}
    task automatic check(input string req, input logic [4:0] exp_f, input logic [7:0] exp_d);
        logic [4:0] act_f;
        act_f = {out_valid, out_for_me, out_direct, out_command, out_special};
        checks++;
        if (act_f !== exp_f || out_data !== exp_d) begin
            errors++;
            $display("FAIL %s: flags=%b data=%02h expected flags=%b data=%02h",
                     req, act_f, out_data, exp_f, exp_d);
        end
    endtask

    // drive one strobe at a falling edge, sample one clock later at the next falling edge
    task automatic send(input logic [7:0] a, input logic [7:0] d);
        in_valid = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 reset", 5'b00000, 8'h00);
    endtask

    task automatic t_short;
        my_short = 8'd5;
        send(8'h0A, 8'h11); check("R1/R6 short5 direct", 5'b11100, 8'h11);
        send(8'h0B, 8'h12); check("R1/R6 short5 command", 5'b11010, 8'h12);
        send(8'h0C, 8'h13); check("R8 short6 mismatch", 5'b10000, 8'h13);
        my_short = 8'd63;
        send(8'h7F, 8'h14); check("R1 short63 command", 5'b11010, 8'h14);
    endtask

    task automatic t_unassigned;
        my_short = 8'hFF;
        send(8'h7E, 8'h21); check("R2 none assigned vs 63", 5'b10000, 8'h21);
        my_short = 8'd64;
        send(8'h00, 8'h22); check("R2 value 64 vs 0", 5'b10000, 8'h22);
        my_short = 8'd5;
    endtask

    task automatic t_group;
        group_mask = 16'h8008;
        send(8'h86, 8'h31); check("R3 group3 direct", 5'b11100, 8'h31);
        send(8'h88, 8'h32); check("R3 group4 not member", 5'b10000, 8'h32);
        send(8'h9F, 8'h33); check("R3 group15 command", 5'b11010, 8'h33);
        send(8'h80, 8'h34); check("R3 group0 not member", 5'b10000, 8'h34);
    endtask

    task automatic t_bcast;
        my_short = 8'hFF; group_mask = 16'h0000;
        send(8'hFE, 8'h41); check("R4 broadcast direct", 5'b11100, 8'h41);
        send(8'hFF, 8'h42); check("R4 broadcast command", 5'b11010, 8'h42);
    endtask

    task automatic t_special;
        send(8'hA0, 8'h51); check("R5 special low edge", 5'b11001, 8'h51);
        send(8'hFD, 8'h52); check("R5 special high edge", 5'b11001, 8'h52);
        send(8'hA1, 8'h53); check("R5 special odd byte", 5'b11001, 8'h53);
        send(8'h9E, 8'h54); check("R3 below special edge", 5'b10000, 8'h54);
    endtask

    task automatic t_b2b;
        my_short = 8'd2; group_mask = 16'h0000;
        in_valid = 1'b1; in_addr = 8'h05; in_data = 8'h61;
        @(negedge clk);
        in_addr = 8'h07; in_data = 8'h62;
        check("R7 first of pair", 5'b11010, 8'h61);
        @(negedge clk);
        in_valid = 1'b0; in_addr = 8'hFE; in_data = 8'h99;
        check("R7 second of pair", 5'b10000, 8'h62);
        @(negedge clk);
        check("R7 no strobe holds data", 5'b00000, 8'h62);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_addr = 8'h00; in_data = 8'h00;
        my_short = 8'd5; group_mask = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short();
        t_unassigned();
        t_group();
        t_bcast();
        t_special();
        t_b2b();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule